// File: doc/BRIEF.md
# Single-Slope Ramp Conversion Controller

This block runs the digital side of a single-slope conversion for a bank of channels that share one ramp. A start pulse marks the end of the settle time of the held levels. From that point the controller steps a ramp code, which an external DAC turns into the analog ramp. Each code is held for a programmable number of clocks. Every channel has its own comparator input. The first rising edge seen on a channel freezes the current ramp code as that channel's result.

The ramp always runs its full programmed length, whatever the comparators do. A channel whose level lies above the top of the ramp therefore still finishes with a defined value, the full-scale code. When the last step has ended, a one-clock done pulse tells the next stage that every result is stable.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: After reset, `ramp_active_o` is 0, `done_o` is 0, `ramp_code_o` is 0, and every channel result is all ones (0x3FFF for the default 14-bit field).
- R2: A high `start_i` is accepted at a clock edge only when no conversion is running. On the clock after an accepted start, `ramp_active_o` is 1 and `ramp_code_o` is 0.
- R3: In a conversion with step limit C and hold value P, `ramp_code_o` goes through 0, 1, …, C. Each code is held P+1 clocks, so `ramp_active_o` is high for exactly (C+1)×(P+1) clocks. In the j-th active cycle after the accepting edge (j counted from 0), the code equals floor(j/(P+1)).
- R4: `ramp_active_o` falls on the edge after the last clock of the last step. On that same edge `done_o` rises, and it stays high for exactly one clock.
- R5: An accepted start loads the full-scale value (all ones) into every channel result.
- R6: Each comparator input passes through two synchronizer flops and then a rising-edge detector. Suppose an input goes high in the m-th active cycle, and it is first sampled at the edge that ends that cycle. The channel then stores floor((m+2)/(P+1)), provided m+2 is less than the ramp length. Otherwise nothing is captured.
- R7: Only the first rising edge of a channel in a conversion is stored. Later falls and rises on that channel leave its result unchanged.
- R8: A channel with no rising edge while the ramp is active keeps full scale. This includes a channel whose input was already high before the start.
- R9: Comparator edges while no conversion is running leave every result unchanged.
- R10: Changes on `start_i`, `step_count_i` and `step_period_i` during a conversion do not alter its length or code sequence. The step limit and the hold value are latched at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a conversion when idle |
| step_count_i | input | CNT_W | Last ramp code of the conversion (C) |
| step_period_i | input | PER_W | Clocks per step minus one (P) |
| cmp_i | input | N_CH | Asynchronous comparator outputs, one per channel |
| ramp_code_o | output | CNT_W | Ramp step code to the DAC |
| ramp_active_o | output | 1 | High while the ramp is running |
| result_o | output | N_CH×CNT_W | Captured codes; channel i at bits [i×CNT_W +: CNT_W] |
| done_o | output | 1 | One-clock pulse after the final step |

## Verification
Ramp shape is tried over several (C, P) pairs:
- The smallest case, C=0 with P=0.
- A long hold on a single code.
- Several codes with a one-clock hold.
- A mixed case.
- A full-scale 0x3FFF ramp.

Together these separate the count-plus-one from the period-plus-one arithmetic. A single multi-channel conversion covers the capture rules:
- One edge on the first cycle.
- Edges in the middle of steps.
- An edge on the last capturable cycle, and one that comes too late.
- A re-toggled channel.
- A channel that never fires.
- A channel that was already high at the start.

This tells apart the synchronizer latency, first-edge locking and full-scale preload. Start and setting changes during a run, and edges while idle, show that latched state is protected.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

  // Clocks a conversion occupies for last code c and hold value p.
  function automatic int unsigned ramp_cycles(input int unsigned c, input int unsigned p);
    return (c + 1) * (p + 1);
  endfunction

  // Ramp code shown in the j-th active cycle.
  function automatic int unsigned code_at(input int unsigned j, input int unsigned p);
    return j / (p + 1);
  endfunction

endpackage

// File: rtl/ramp_step_seq.sv
module ramp_step_seq #(
  parameter int CNT_W = 14,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [PER_W-1:0] period_i,
  output logic [CNT_W-1:0] code_o,
  output logic             active_o,
  output logic             done_o,
  output logic             accept_o,
  output logic             step_end_o,
  output logic [CNT_W-1:0] limit_o,
  output logic [PER_W-1:0] period_o
);

  logic [CNT_W-1:0] code_q, limit_q;
  logic [PER_W-1:0] per_q, tmr_q;
  logic             active_q, done_q;
  logic             accept, step_end, last_step;

  assign accept    = start_i & ~active_q;
  assign step_end  = active_q & (tmr_q == per_q);
  assign last_step = step_end & (code_q == limit_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q   <= '0;
      limit_q  <= '0;
      per_q    <= '0;
      tmr_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        limit_q  <= count_i;
        per_q    <= period_i;
        code_q   <= '0;
        tmr_q    <= '0;
        active_q <= 1'b1;
      end else if (active_q) begin
        if (step_end) begin
          tmr_q <= '0;
          if (last_step) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            code_q <= code_q + 1'b1;
          end
        end else begin
          tmr_q <= tmr_q + 1'b1;
        end
      end
    end
  end

  assign code_o     = code_q;
  assign active_o   = active_q;
  assign done_o     = done_q;
  assign accept_o   = accept;
  assign step_end_o = step_end;
  assign limit_o    = limit_q;
  assign period_o   = per_q;

endmodule

// File: rtl/cmp_edge_sync.sv
module cmp_edge_sync #(
  parameter int N_CH        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] cmp_i,
  output logic [N_CH-1:0] rise_o
);

  localparam int TOP = SYNC_STAGES - 1;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [SYNC_STAGES-1:0] shift_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shift_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        shift_q <= {shift_q[TOP-1:0], cmp_i[ch]};
        prev_q  <= shift_q[TOP];
      end
    end

    assign rise_o[ch] = shift_q[TOP] & ~prev_q;
  end

endmodule

// File: rtl/capture_bank.sv
module capture_bank #(
  parameter int N_CH  = 8,
  parameter int CNT_W = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear_i,
  input  logic                  active_i,
  input  logic [N_CH-1:0]       rise_i,
  input  logic [CNT_W-1:0]      code_i,
  output logic [N_CH*CNT_W-1:0] result_o,
  output logic [N_CH-1:0]       captured_o
);

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [CNT_W-1:0] res_q;
    logic             cap_q;

    always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
        res_q <= '1;
        cap_q <= 1'b0;
      end else if (active_i && rise_i[ch] && !cap_q) begin
        res_q <= code_i;
        cap_q <= 1'b1;
      end
    end

    assign result_o[ch*CNT_W +: CNT_W] = res_q;
    assign captured_o[ch]              = cap_q;
  end

endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
  parameter int N_CH        = 8,
  parameter int CNT_W       = 14,
  parameter int PER_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [CNT_W-1:0]      step_count_i,
  input  logic [PER_W-1:0]      step_period_i,
  input  logic [N_CH-1:0]       cmp_i,
  output logic [CNT_W-1:0]      ramp_code_o,
  output logic                  ramp_active_o,
  output logic [N_CH*CNT_W-1:0] result_o,
  output logic                  done_o
);

  localparam int RES_W = N_CH * CNT_W;

  logic             start_accept, ramp_active, conv_done, step_end;
  logic [CNT_W-1:0] ramp_code, step_limit;
  logic [PER_W-1:0] step_period;
  logic [N_CH-1:0]  cmp_rise, chan_captured;
  logic [RES_W-1:0] chan_result;

  ramp_step_seq #(.CNT_W(CNT_W), .PER_W(PER_W)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .count_i    (step_count_i),
    .period_i   (step_period_i),
    .code_o     (ramp_code),
    .active_o   (ramp_active),
    .done_o     (conv_done),
    .accept_o   (start_accept),
    .step_end_o (step_end),
    .limit_o    (step_limit),
    .period_o   (step_period)
  );

  cmp_edge_sync #(.N_CH(N_CH), .SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmp_i  (cmp_i),
    .rise_o (cmp_rise)
  );

  capture_bank #(.N_CH(N_CH), .CNT_W(CNT_W)) i_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (start_accept),
    .active_i   (ramp_active),
    .rise_i     (cmp_rise),
    .code_i     (ramp_code),
    .result_o   (chan_result),
    .captured_o (chan_captured)
  );

  assign ramp_code_o   = ramp_code;
  assign ramp_active_o = ramp_active;
  assign result_o      = chan_result;
  assign done_o        = conv_done;

endmodule

// File: rtl/ramp_adc_ctrl_chk.sv
module ramp_adc_ctrl_chk #(
  parameter int N_CH  = 8,
  parameter int CNT_W = 14,
  parameter int PER_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_accept,
  input logic                  ramp_active,
  input logic                  conv_done,
  input logic                  step_end,
  input logic [CNT_W-1:0]      ramp_code,
  input logic [CNT_W-1:0]      step_limit,
  input logic [PER_W-1:0]      step_period,
  input logic [N_CH-1:0]       chan_captured,
  input logic [N_CH*CNT_W-1:0] result_o
);
  import ramp_adc_pkg::*;

  int unsigned len_q;

  always_ff @(posedge clk) begin
    if (!rst_n || start_accept) len_q <= 0;
    else if (ramp_active)       len_q <= len_q + 1;
  end

  p_code_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_active |-> ramp_code <= step_limit);

  p_code_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_active && $past(ramp_active) && !$past(step_end)) |-> ramp_code == $past(ramp_code));

  p_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> len_q == ramp_cycles(32'(step_limit), 32'(step_period)));

  p_done_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> (!ramp_active && $past(ramp_active)));

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_done);

  p_preload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> (result_o == '1 && chan_captured == '0));

  p_first_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_active && !start_accept) |=> ((chan_captured & $past(chan_captured)) == $past(chan_captured)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ramp_active && !start_accept) |=> $stable(result_o));

endmodule

bind ramp_adc_ctrl ramp_adc_ctrl_chk #(.N_CH(N_CH), .CNT_W(CNT_W), .PER_W(PER_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_accept  (start_accept),
  .ramp_active   (ramp_active),
  .conv_done     (conv_done),
  .step_end      (step_end),
  .ramp_code     (ramp_code),
  .step_limit    (step_limit),
  .step_period   (step_period),
  .chan_captured (chan_captured),
  .result_o      (result_o)
);

// File: tb/test_ramp_adc_ctrl.sv
`timescale 1ns/1ps
module test_ramp_adc_ctrl;
  localparam int N_CH  = 8;
  localparam int CNT_W = 14;
  localparam int PER_W = 8;
  localparam int FULL  = (1 << CNT_W) - 1;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  start_i = 1'b0;
  logic [CNT_W-1:0]      step_count_i = '0;
  logic [PER_W-1:0]      step_period_i = '0;
  logic [N_CH-1:0]       cmp_i = '0;
  logic [CNT_W-1:0]      ramp_code_o;
  logic                  ramp_active_o;
  logic [N_CH*CNT_W-1:0] result_o;
  logic                  done_o;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ramp_adc_ctrl #(.N_CH(N_CH), .CNT_W(CNT_W), .PER_W(PER_W)) i_ramp_adc_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .step_count_i  (step_count_i),
    .step_period_i (step_period_i),
    .cmp_i         (cmp_i),
    .ramp_code_o   (ramp_code_o),
    .ramp_active_o (ramp_active_o),
    .result_o      (result_o),
    .done_o        (done_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int res(input int ch);
    return int'(result_o[ch*CNT_W +: CNT_W]);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Leaves the bench at the falling edge after the accepting edge (active cycle 0).
  task automatic kick(input int c, input int p);
    @(negedge clk);
    step_count_i  = CNT_W'(c);
    step_period_i = PER_W'(p);
    start_i       = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 100000 && !done_o; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "active", int'(ramp_active_o), 0);
    chk("R1", "done", int'(done_o), 0);
    chk("R1", "code", int'(ramp_code_o), 0);
    for (int ch = 0; ch < N_CH; ch++) chk("R1", "result full scale", res(ch), FULL);
  endtask

  // Shape of one conversion; disturb pokes start and settings mid-run (R10, R2).
  task automatic t_shape(input int c, input int p, input bit disturb);
    int n = 0;
    int bad = 0;
    int first = -1;
    kick(c, p);
    chk("R2", "active after start", int'(ramp_active_o), 1);
    chk("R5", "preload ch0", res(0), FULL);
    while (ramp_active_o && n < 70000) begin
      if (int'(ramp_code_o) != n / (p + 1)) begin
        bad++;
        if (first < 0) first = int'(ramp_code_o);
      end
      if (disturb && n == 2) begin
        start_i = 1'b1;
        step_count_i  = '0;
        step_period_i = '0;
      end
      if (disturb && n == 3) start_i = 1'b0;
      n++;
      @(negedge clk);
    end
    chk(disturb ? "R10" : "R3", "active length", n, (c + 1) * (p + 1));
    chk("R3", "code sequence errors", bad, 0);
    chk("R3", "final code", int'(ramp_code_o), c);
    chk("R4", "done after last step", int'(done_o), 1);
    @(negedge clk);
    chk("R4", "done one clock", int'(done_o), 0);
    cyc(2);
  endtask

  task automatic t_capture();
    int snap;
    cmp_i[5] = 1'b1;          // already high before start
    cyc(4);
    kick(5, 2);               // length 18
    cmp_i[0] = 1'b1;          // m=0
    cyc(4); cmp_i[1] = 1'b1;  // m=4
    cyc(3); cmp_i[6] = 1'b1;  // m=7
    cyc(2); cmp_i[6] = 1'b0;  // m=9
    cyc(1); cmp_i[2] = 1'b1;  // m=10
    cyc(2); cmp_i[6] = 1'b1;  // m=12, second rise
    cyc(3); cmp_i[3] = 1'b1;  // m=15, last capturable
    cyc(1); cmp_i[7] = 1'b1;  // m=16, too late
    wait_done();
    cyc(3);
    chk("R6", "ch0 m=0", res(0), 0);
    chk("R6", "ch1 m=4", res(1), 2);
    chk("R6", "ch2 m=10", res(2), 4);
    chk("R6", "ch3 m=15", res(3), 5);
    chk("R7", "ch6 retoggle", res(6), 3);
    chk("R8", "ch4 never", res(4), FULL);
    chk("R8", "ch5 high before start", res(5), FULL);
    chk("R6", "ch7 too late", res(7), FULL);
    // idle edges (R9)
    snap = res(4);
    cmp_i = '0;
    cyc(4);
    cmp_i[4] = 1'b1;
    cyc(5);
    chk("R9", "idle edge ch4", res(4), snap);
    chk("R9", "ch1 kept", res(1), 2);
    cmp_i = '0;
    cyc(4);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_shape(0, 0, 1'b0);
    t_shape(3, 0, 1'b0);
    t_shape(0, 4, 1'b0);
    t_shape(6, 3, 1'b0);
    t_shape(4, 1, 1'b1);
    t_capture();
    t_shape(FULL, 0, 1'b0);
    chk("R8", "full ramp idle channel", res(0), FULL);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R3 watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule